// File: doc/BRIEF.md
# Double-Buffered Prescaled Backlight PWM

This block produces one pulse-width-modulated output for a display backlight. A 10-bit prescaler stretches every step of a 12-bit period counter over several input clocks. The output stays high while the period counter is below a 13-bit high-time value, so both the frequency and the duty cycle of the pulse are set in whole input-clock units.

Software sets the block up through a small register bus. Writes to the two configuration words go to shadow copies. A commit handshake on a separate register schedules those copies for the active counters. While the output runs, the hand-over waits for the end of the current period, so no pulse is ever cut short or stretched. A bypass setting in a mode register lets configuration writes go straight to the active values, with no commit. Reads always return the shadow copies.

Byte addresses (word aligned): 0x00 run control, 0x04 prescale word, 0x08 span word, 0x0C commit, 0x10 mode. Read data is combinational from `bus_addr`.

Top module: `bkl_pwm_top`

## Requirements
- R1: With prescale value D and period value P active and the output running, one output period lasts (D+1)*(P+1) clock cycles.
- R2: With high value H and H no greater than P, the output is high for H*(D+1) cycles at the start of each period.
- R3: D sits in bits 25:16 of the word at 0x04. P sits in bits 11:0 and H in bits 28:16 of the word at 0x08.
- R4: Writes to 0x04 or 0x08 change the output only after bit 0 of 0x0C is written 1 and then 0. Without that sequence the active values keep their old contents.
- R5: Bit 0 of 0x00 runs the output. While it is 0 the output is low and the prescaler and period counters are held at zero, so a new run starts at the beginning of a period.
- R6: When bits 1:0 of the mode word at 0x10 both read 1, writes to 0x04 and 0x08 take effect in the active values on the same clock edge, with no commit.
- R7: A commit made while the output runs reaches the active values only at the next period boundary. A commit made while stopped takes effect at once.
- R8: When H is at least P+1 the output stays high for the whole period. When H is 0 the output stays low.
- R9: Reads return the shadow contents of each register. Unused bits and unmapped addresses read 0.
- R10: After reset every register and every active value is 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_out | output | 1 | PWM output |

## Verification
The bench targets a commit issued partway through a running period. A design that loaded it at once would produce a truncated pulse, which shows up as a mismatch against the cycle model. Configuration writes made without a commit must leave the waveform unchanged; a design that leaked shadow values would change the pulse early. The bench also covers a high value equal to or far above P+1, and a high value of 0. Off-by-one errors in the comparison show up as a stray low or high cycle. Stopping and restarting the output must restart at the beginning of a period, and the bypass mode must act without a commit. A design that kept its counters through a stop, or that ignored the mode bits, would be out of phase with the model.

// File: rtl/bkl_pwm_pkg.sv
package bkl_pwm_pkg;
  localparam int unsigned DEF_DIV_W  = 10;
  localparam int unsigned DEF_PER_W  = 12;
  localparam int unsigned DEF_HIGH_W = 13;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_ADDR_W = 5;

  // field positions inside the configuration words
  localparam int unsigned DIV_LSB  = 16;
  localparam int unsigned PER_LSB  = 0;
  localparam int unsigned HIGH_LSB = 16;

  // word indices (byte address / 4)
  localparam int unsigned IDX_RUN    = 0;
  localparam int unsigned IDX_PRESC  = 1;
  localparam int unsigned IDX_SPAN   = 2;
  localparam int unsigned IDX_COMMIT = 3;
  localparam int unsigned IDX_MODE   = 4;

  localparam int unsigned MODE_W = 2;
endpackage

// File: rtl/bkl_pwm_regs.sv
module bkl_pwm_regs
  import bkl_pwm_pkg::*;
#(
  parameter int unsigned DIV_W  = DEF_DIV_W,
  parameter int unsigned PER_W  = DEF_PER_W,
  parameter int unsigned HIGH_W = DEF_HIGH_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              run_q,
  output logic              bypass,
  output logic              commit_fall,
  output logic              wr_presc,
  output logic              wr_span,
  output logic [DIV_W-1:0]  wf_div,
  output logic [PER_W-1:0]  wf_per,
  output logic [HIGH_W-1:0] wf_high,
  output logic [DIV_W-1:0]  sh_div,
  output logic [PER_W-1:0]  sh_per,
  output logic [HIGH_W-1:0] sh_high
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              wr;
  logic              hit_run, hit_commit, hit_mode;
  logic              commit_q, commit_d, run_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [DIV_W-1:0]  sh_div_d;
  logic [PER_W-1:0]  sh_per_d;
  logic [HIGH_W-1:0] sh_high_d;

  assign idx = bus_addr[ADDR_W-1:2];
  assign wr  = bus_sel & bus_wr;

  assign hit_run    = wr && (idx == IDX_W'(IDX_RUN));
  assign wr_presc   = wr && (idx == IDX_W'(IDX_PRESC));
  assign wr_span    = wr && (idx == IDX_W'(IDX_SPAN));
  assign hit_commit = wr && (idx == IDX_W'(IDX_COMMIT));
  assign hit_mode   = wr && (idx == IDX_W'(IDX_MODE));

  assign wf_div  = bus_wdata[DIV_LSB  +: DIV_W];
  assign wf_per  = bus_wdata[PER_LSB  +: PER_W];
  assign wf_high = bus_wdata[HIGH_LSB +: HIGH_W];

  assign commit_fall = hit_commit & ~bus_wdata[0] & commit_q;
  assign bypass      = &mode_q;

  always_comb begin
    run_d     = run_q;
    commit_d  = commit_q;
    mode_d    = mode_q;
    sh_div_d  = sh_div;
    sh_per_d  = sh_per;
    sh_high_d = sh_high;
    if (hit_run)    run_d    = bus_wdata[0];
    if (hit_commit) commit_d = bus_wdata[0];
    if (hit_mode)   mode_d   = bus_wdata[MODE_W-1:0];
    if (wr_presc)   sh_div_d = wf_div;
    if (wr_span) begin
      sh_per_d  = wf_per;
      sh_high_d = wf_high;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      commit_q <= 1'b0;
      mode_q   <= '0;
    end else begin
      if (hit_run)    run_q    <= run_d;
      if (hit_commit) commit_q <= commit_d;
      if (hit_mode)   mode_q   <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div  <= '0;
      sh_per  <= '0;
      sh_high <= '0;
    end else begin
      if (wr_presc) sh_div <= sh_div_d;
      if (wr_span) begin
        sh_per  <= sh_per_d;
        sh_high <= sh_high_d;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IDX_W'(IDX_RUN):    bus_rdata[0] = run_q;
      IDX_W'(IDX_PRESC):  bus_rdata[DIV_LSB +: DIV_W] = sh_div;
      IDX_W'(IDX_SPAN): begin
        bus_rdata[PER_LSB  +: PER_W]  = sh_per;
        bus_rdata[HIGH_LSB +: HIGH_W] = sh_high;
      end
      IDX_W'(IDX_COMMIT): bus_rdata[0] = commit_q;
      IDX_W'(IDX_MODE):   bus_rdata[MODE_W-1:0] = mode_q;
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bkl_pwm_active.sv
module bkl_pwm_active #(
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned PER_W  = 12,
  parameter int unsigned HIGH_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_q,
  input  logic              boundary,
  input  logic              commit_fall,
  input  logic              bypass,
  input  logic              wr_presc,
  input  logic              wr_span,
  input  logic [DIV_W-1:0]  wf_div,
  input  logic [PER_W-1:0]  wf_per,
  input  logic [HIGH_W-1:0] wf_high,
  input  logic [DIV_W-1:0]  sh_div,
  input  logic [PER_W-1:0]  sh_per,
  input  logic [HIGH_W-1:0] sh_high,
  output logic [DIV_W-1:0]  act_div,
  output logic [PER_W-1:0]  act_per,
  output logic [HIGH_W-1:0] act_high
);
  logic              pend_q, pend_d;
  logic              apply;
  logic              load_div, load_span;
  logic [DIV_W-1:0]  act_div_d;
  logic [PER_W-1:0]  act_per_d;
  logic [HIGH_W-1:0] act_high_d;

  // a commit while stopped lands at once; while running, at the period end
  assign apply = (pend_q & (~run_q | boundary)) | (commit_fall & ~run_q);

  always_comb begin
    if (commit_fall && run_q) pend_d = 1'b1;
    else if (apply)           pend_d = 1'b0;
    else                      pend_d = pend_q;
  end

  assign load_div  = apply | (bypass & wr_presc);
  assign load_span = apply | (bypass & wr_span);

  always_comb begin
    act_div_d  = act_div;
    act_per_d  = act_per;
    act_high_d = act_high;
    if (apply) begin
      act_div_d  = sh_div;
      act_per_d  = sh_per;
      act_high_d = sh_high;
    end
    if (bypass && wr_presc) act_div_d = wf_div;
    if (bypass && wr_span) begin
      act_per_d  = wf_per;
      act_high_d = wf_high;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div  <= '0;
      act_per  <= '0;
      act_high <= '0;
    end else begin
      if (load_div) act_div <= act_div_d;
      if (load_span) begin
        act_per  <= act_per_d;
        act_high <= act_high_d;
      end
    end
  end
endmodule

// File: rtl/bkl_pwm_timebase.sv
module bkl_pwm_timebase #(
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned PER_W  = 12,
  parameter int unsigned HIGH_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_q,
  input  logic [DIV_W-1:0]  act_div,
  input  logic [PER_W-1:0]  act_per,
  input  logic [HIGH_W-1:0] act_high,
  output logic              boundary,
  output logic [PER_W-1:0]  per_cnt,
  output logic              pwm_out
);
  localparam int unsigned CMP_W = (HIGH_W > PER_W) ? HIGH_W : PER_W;

  logic [DIV_W-1:0] pre_q, pre_d;
  logic [PER_W-1:0] per_d;
  logic             tick, last;

  assign tick     = (pre_q >= act_div);
  assign last     = (per_cnt >= act_per);
  assign boundary = run_q & tick & last;

  always_comb begin
    pre_d = pre_q;
    per_d = per_cnt;
    if (!run_q) begin
      pre_d = '0;
      per_d = '0;
    end else if (tick) begin
      pre_d = '0;
      per_d = last ? '0 : per_cnt + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      per_cnt <= '0;
    end else begin
      pre_q   <= pre_d;
      per_cnt <= per_d;
    end
  end

  assign pwm_out = run_q & (CMP_W'(per_cnt) < CMP_W'(act_high));
endmodule

// File: rtl/bkl_pwm_top.sv
module bkl_pwm_top
  import bkl_pwm_pkg::*;
#(
  parameter int unsigned DIV_W  = DEF_DIV_W,
  parameter int unsigned PER_W  = DEF_PER_W,
  parameter int unsigned HIGH_W = DEF_HIGH_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              run_q, bypass, commit_fall, wr_presc, wr_span, boundary;
  logic [DIV_W-1:0]  wf_div, sh_div, act_div;
  logic [PER_W-1:0]  wf_per, sh_per, act_per, per_cnt;
  logic [HIGH_W-1:0] wf_high, sh_high, act_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  bkl_pwm_regs #(
    .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n_s),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .run_q(run_q), .bypass(bypass), .commit_fall(commit_fall),
    .wr_presc(wr_presc), .wr_span(wr_span),
    .wf_div(wf_div), .wf_per(wf_per), .wf_high(wf_high),
    .sh_div(sh_div), .sh_per(sh_per), .sh_high(sh_high)
  );

  bkl_pwm_active #(
    .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
  ) active_i (
    .clk(clk), .rst_n(rst_n_s),
    .run_q(run_q), .boundary(boundary), .commit_fall(commit_fall),
    .bypass(bypass), .wr_presc(wr_presc), .wr_span(wr_span),
    .wf_div(wf_div), .wf_per(wf_per), .wf_high(wf_high),
    .sh_div(sh_div), .sh_per(sh_per), .sh_high(sh_high),
    .act_div(act_div), .act_per(act_per), .act_high(act_high)
  );

  bkl_pwm_timebase #(
    .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
  ) timebase_i (
    .clk(clk), .rst_n(rst_n_s),
    .run_q(run_q), .act_div(act_div), .act_per(act_per), .act_high(act_high),
    .boundary(boundary), .per_cnt(per_cnt), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/bkl_pwm_chk.sv
module bkl_pwm_chk #(
  parameter int unsigned DIV_W  = 10,
  parameter int unsigned PER_W  = 12,
  parameter int unsigned HIGH_W = 13
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              run_q,
  input logic              bypass,
  input logic              boundary,
  input logic              pwm_out,
  input logic [DIV_W-1:0]  act_div,
  input logic [PER_W-1:0]  act_per,
  input logic [HIGH_W-1:0] act_high,
  input logic [PER_W-1:0]  per_cnt
);
  localparam int unsigned CMP_W = ((HIGH_W > PER_W) ? HIGH_W : PER_W) + 1;

  // R5: stopped output is low
  p_low_when_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !run_q |-> !pwm_out);

  // R8: zero high value keeps the output low
  p_zero_high_low_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (act_high == '0) |-> !pwm_out);

  // R8: high value beyond the period keeps the output high
  p_full_high_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run_q && per_cnt <= act_per &&
     (CMP_W'(act_high) > CMP_W'(act_per))) |-> pwm_out);

  // R7: while running without bypass, active values move only at a boundary
  p_hold_midperiod_div_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run_q && !boundary && !bypass) |=> $stable(act_div));
  p_hold_midperiod_span_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (run_q && !boundary && !bypass) |=> ($stable(act_per) && $stable(act_high)));

  // R5: a stopped timebase restarts from the first step
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !run_q |=> (per_cnt == '0));
endmodule

bind bkl_pwm_top bkl_pwm_chk #(
  .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
) chk_i (
  .clk(clk), .rst_n_s(rst_n_s), .run_q(run_q), .bypass(bypass),
  .boundary(boundary), .pwm_out(pwm_out), .act_div(act_div),
  .act_per(act_per), .act_high(act_high), .per_cnt(per_cnt)
);

// File: tb/bkl_pwm_top_tb_top.sv
module bkl_pwm_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_on = 0;
  string tag = "R10";

  bkl_pwm_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  initial clk = 0;
  always #4 clk = ~clk;   // 125 MHz

  // ---------------- behavioural reference model ----------------
  int m_run, m_commit, m_mode, m_pend, m_t;
  int m_sdiv, m_sper, m_shigh, m_adiv, m_aper, m_ahigh;

  function automatic int model_out();
    return (m_run != 0 && m_t < m_ahigh * (m_adiv + 1)) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_commit = 0; m_mode = 0; m_pend = 0; m_t = 0;
      m_sdiv = 0; m_sper = 0; m_shigh = 0; m_adiv = 0; m_aper = 0; m_ahigh = 0;
    end else begin
      automatic int w    = (bus_sel && bus_wr) ? 1 : 0;
      automatic int a    = int'(bus_addr) / 4;
      automatic int tot  = (m_adiv + 1) * (m_aper + 1);
      automatic int bnd  = (m_run != 0 && m_t == tot - 1) ? 1 : 0;
      automatic int cf   = (w != 0 && a == 3 && !bus_wdata[0] && m_commit != 0) ? 1 : 0;
      automatic int app  = ((m_pend != 0 && (m_run == 0 || bnd != 0)) ||
                            (cf != 0 && m_run == 0)) ? 1 : 0;
      automatic int byp  = (m_mode == 3) ? 1 : 0;
      m_t = (m_run == 0 || bnd != 0) ? 0 : m_t + 1;
      if (cf != 0 && m_run != 0) m_pend = 1;
      else if (app != 0)         m_pend = 0;
      if (app != 0) begin
        m_adiv = m_sdiv; m_aper = m_sper; m_ahigh = m_shigh;
      end
      if (w != 0) begin
        case (a)
          0: m_run = bus_wdata[0];
          1: begin
            m_sdiv = int'(bus_wdata[25:16]);
            if (byp != 0) m_adiv = m_sdiv;
          end
          2: begin
            m_sper  = int'(bus_wdata[11:0]);
            m_shigh = int'(bus_wdata[28:16]);
            if (byp != 0) begin m_aper = m_sper; m_ahigh = m_shigh; end
          end
          3: m_commit = bus_wdata[0];
          4: m_mode = int'(bus_wdata[1:0]);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (int'(pwm_out) != model_out()) begin
        fails++;
        $display("FAIL %s pwm_out actual=%0d expected=%0d at %0t", tag, pwm_out, model_out(), $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic bus_write(input logic [4:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic check_read(input logic [4:0] addr, input logic [31:0] exp, input string rq);
    @(negedge clk);
    bus_addr = addr;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s read 0x%02h actual=0x%08h expected=0x%08h", rq, addr, bus_rdata, exp);
    end
  endtask

  task automatic check_val(input int act, input int exp, input string rq, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic commit();
    bus_write(5'h0C, 32'h1);
    bus_write(5'h0C, 32'h0);
  endtask

  task automatic cfg(input int d, input int p, input int h);
    bus_write(5'h04, 32'(d) << 16);
    bus_write(5'h08, (32'(h) << 16) | 32'(p));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // measure high cycles and period length at the output
  task automatic measure(output int hi, output int per);
    int guard = 0;
    hi = 0; per = 0;
    while (pwm_out !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    while (pwm_out !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
    while (pwm_out === 1'b1 && guard < 5000) begin hi++; per++; @(negedge clk); guard++; end
    while (pwm_out === 1'b0 && guard < 5000) begin per++; @(negedge clk); guard++; end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi, per;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    cmp_on = 1;

    // R10: reset state
    tag = "R10";
    check_read(5'h00, 32'h0, "R10");
    check_read(5'h04, 32'h0, "R10");
    check_read(5'h08, 32'h0, "R10");
    check_read(5'h10, 32'h0, "R10");
    check_val(int'(pwm_out), 0, "R10", "out after reset");

    // R3/R9: field positions and masking of unused bits
    tag = "R3";
    bus_write(5'h04, 32'hFFFF_FFFF);
    bus_write(5'h08, 32'hFFFF_FFFF);
    check_read(5'h04, 32'h03FF_0000, "R3");
    check_read(5'h08, 32'h1FFF_0FFF, "R3");
    check_read(5'h14, 32'h0, "R9");
    check_read(5'h1C, 32'h0, "R9");

    // R4: shadow writes without commit leave output idle while running
    tag = "R4";
    cfg(2, 4, 2);
    check_read(5'h08, 32'h0002_0004, "R9");
    bus_write(5'h00, 32'h1);
    idle(30);
    check_val(int'(pwm_out), 0, "R4", "out before commit");

    // R1/R2: commit while running; measure waveform
    tag = "R1";
    commit();
    idle(20);
    measure(hi, per);
    check_val(per, 15, "R1", "period cycles");
    check_val(hi, 6, "R2", "high cycles");

    tag = "R2";
    cfg(0, 9, 3);
    commit();
    idle(15);
    measure(hi, per);
    check_val(per, 10, "R1", "period cycles div0");
    check_val(hi, 3, "R2", "high cycles div0");

    // R7: commit mid-period lands at the boundary only (model checks each cycle)
    tag = "R7";
    cfg(3, 7, 5);
    commit();
    idle(40);
    cfg(1, 5, 2);
    idle(5);
    commit();
    idle(40);
    measure(hi, per);
    check_val(per, 12, "R7", "period after boundary commit");

    // R8: full high and zero high
    tag = "R8";
    cfg(1, 5, 6);
    commit();
    idle(30);
    check_val(int'(pwm_out), 1, "R8", "out with high = period+1");
    cfg(1, 5, 4095);
    commit();
    idle(30);
    check_val(int'(pwm_out), 1, "R8", "out with large high");
    cfg(1, 5, 0);
    commit();
    idle(30);
    check_val(int'(pwm_out), 0, "R8", "out with zero high");

    // R5: stop forces low, restart from period start
    tag = "R5";
    cfg(2, 3, 2);
    commit();
    idle(25);
    bus_write(5'h00, 32'h0);
    check_val(int'(pwm_out), 0, "R5", "out when stopped");
    idle(10);
    bus_write(5'h00, 32'hFFFF_FFFF);
    check_read(5'h00, 32'h1, "R9");
    idle(30);

    // R6: bypass mode, writes act with no commit
    tag = "R6";
    bus_write(5'h00, 32'h0);
    bus_write(5'h10, 32'h7);
    check_read(5'h10, 32'h3, "R6");
    cfg(0, 3, 4);
    bus_write(5'h00, 32'h1);
    idle(10);
    check_val(int'(pwm_out), 1, "R6", "bypass full-high without commit");
    bus_write(5'h00, 32'h0);
    cfg(1, 4, 1);
    bus_write(5'h00, 32'h1);
    idle(3);
    measure(hi, per);
    check_val(per, 10, "R6", "bypass period");
    check_val(hi, 2, "R6", "bypass high");

    // R4: with bypass off, stopped-state write needs commit
    tag = "R4";
    bus_write(5'h00, 32'h0);
    bus_write(5'h10, 32'h1);
    cfg(0, 3, 0);
    bus_write(5'h00, 32'h1);
    idle(12);
    check_val(int'(pwm_out) | 0, model_out(), "R4", "no bypass with one mode bit");
    idle(10);

    cmp_on = 0;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule